// File: doc/BRIEF.md
# Multi-mode ADC serial output formatter

This block takes the 14-bit conversion results of one converter channel and sends them out as serial bits on one or two data lanes. It also produces a forwarded data clock and a frame marker that a downstream receiver uses to rebuild the parallel words. Everything runs on one internal bit-rate clock, with one clock cycle per serial bit period. The forwarded clock inverts once per bit period, so a receiver captures data on both of its edges.

Two static selects choose the format. The lane select picks one or two lanes. The length select picks a serialized word of 16 bits (the sample plus two zero pad bits), 14 bits (the sample), or 12 bits (the sample without its two least significant bits). Samples arrive with a valid strobe and wait in a small buffer until the next frame boundary takes them. In two-lane 14-bit format one frame carries two samples back to back, so the frame marker runs at half the sample rate. A format change is only taken up at a frame boundary. Once frames have started, a boundary that finds too few buffered samples still sends a frame, filled with zeros, so the clock and the marker keep running.

Top module: `adc_ser_formatter`

## Requirements
- R1: While reset is asserted, and after reset until the first frame starts, lane_a, lane_b, bit_clk_out and frame_mark are all low. Asserting reset during a frame forces them low at once.
- R2: A sample accepted at a clock edge can be used by a frame load from the next edge on. From idle, the first frame loads at the first edge where the buffer holds the samples the frame needs: two in two-lane 14-bit format, one otherwise.
- R3: The frame length in bit periods is 16, 14 or 12 in one-lane format, and 8, 14 or 6 in two-lane format, for ser_len = 0 (16-bit), 1 (14-bit) and 2 (12-bit). The value 3 behaves as 16-bit. lane_sel = 1 selects two lanes.
- R4: Serialized word, position 0 sent first. In 16-bit format it is sample bits 13 down to 0 followed by two zeros. In 14-bit format it is bits 13 down to 0. In 12-bit format it is bits 13 down to 2. In two-lane 14-bit format the frame word is the older sample's 14 bits followed by the newer sample's 14 bits.
- R5: In one-lane format, lane_a carries word position k in bit period k and lane_b stays low. In two-lane format, lane_a carries position 2k and lane_b carries position 2k+1 in bit period k.
- R6: frame_mark is high in bit period k of a frame when 2k is less than the frame length, and low otherwise.
- R7: bit_clk_out is high in the first bit period after leaving idle. It then inverts every bit period, without a break across frame boundaries.
- R8: Once frames have started, a boundary at which the buffer holds too few samples sends an all-zero frame of the current length, with frame_mark and bit_clk_out unchanged in behaviour, and consumes no sample. A sample whose strobe falls on the boundary edge itself is therefore sent one frame later.
- R9: A change on lane_sel or ser_len during a frame does not alter that frame. The new format governs from the next frame load on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one cycle per serial bit period |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 14 | Conversion result |
| smp_vld | input | 1 | Strobe: smp_data is taken at this edge |
| lane_sel | input | 1 | 0: one lane, 1: two lanes |
| ser_len | input | 2 | 0: 16-bit, 1: 14-bit, 2: 12-bit serialization |
| lane_a | output | 1 | Serial data lane 0 |
| lane_b | output | 1 | Serial data lane 1 (low in one-lane format) |
| bit_clk_out | output | 1 | Forwarded data clock, inverts each bit period |
| frame_mark | output | 1 | Frame marker, high in the first half of a frame |

## Verification
Two things can land on the same edge: a sample strobe and a frame boundary load. At that edge the buffer has not yet stored the arriving sample. The bench provokes this by raising the strobe in the last bit period of a frame. It then expects one all-zero frame followed by a frame that carries the late sample, and compares this with a strobe raised in the middle of a frame, which must appear in the very next frame. A format change raised in the middle of a frame is also judged at that boundary: the old frame must run to its full old length, and the next one must take the new length and lane mapping.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  localparam int SMP_W   = 14;
  localparam int PAD_W   = 2;
  localparam int DROP_W  = 2;
  localparam int WORD_W  = 2 * SMP_W;
  localparam int PER_MAX = SMP_W + PAD_W;
  localparam int CNT_W   = $clog2(PER_MAX + 1);

  typedef enum logic [1:0] {
    LEN_16  = 2'd0,
    LEN_14  = 2'd1,
    LEN_12  = 2'd2,
    LEN_RSV = 2'd3
  } len_e;

  typedef struct packed {
    logic two_lane;
    len_e len;
  } mode_t;

  // Two samples share one frame only in two-lane 14-bit format.
  function automatic logic pair_frame(mode_t m);
    return m.two_lane && (m.len == LEN_14);
  endfunction

  // Frame length in bit periods.
  function automatic logic [CNT_W-1:0] frame_periods(mode_t m);
    int base;
    case (m.len)
      LEN_14:  base = SMP_W;
      LEN_12:  base = SMP_W - DROP_W;
      default: base = SMP_W + PAD_W;
    endcase
    if (m.two_lane) base = pair_frame(m) ? SMP_W : base / 2;
    return CNT_W'(base);
  endfunction

  // Left-aligned frame word; the MSB is sent first.
  function automatic logic [WORD_W-1:0] build_word(mode_t m,
                                                   logic [SMP_W-1:0] a,
                                                   logic [SMP_W-1:0] b);
    logic [WORD_W-1:0] w;
    case (m.len)
      LEN_14:  w = pair_frame(m) ? {a, b} : {a, {SMP_W{1'b0}}};
      LEN_12:  w = {a[SMP_W-1:DROP_W], {(WORD_W - SMP_W + DROP_W){1'b0}}};
      default: w = {a, {(WORD_W - SMP_W){1'b0}}};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/adc_ser_fifo.sv
module adc_ser_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 14,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic [1:0]    pop_n,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1,
  output logic [CW-1:0] level
);

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]     mem [DEPTH];
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    lvl_q, lvl_d;
  logic             accept;
  logic [DEPTH-1:0] wr_en;

  // A push is taken if the slot frees up through this cycle's pops.
  always_comb begin
    accept = push && ((lvl_q - CW'(pop_n)) < CW'(DEPTH));
    wr_d   = accept ? ptr_inc(wr_q) : wr_q;
    case (pop_n)
      2'd1:    rd_d = ptr_inc(rd_q);
      2'd2:    rd_d = ptr_inc(ptr_inc(rd_q));
      default: rd_d = rd_q;
    endcase
    lvl_d = lvl_q - CW'(pop_n) + CW'(accept);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_wen
    assign wr_en[i] = accept && (wr_q == PW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i]) mem[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  assign head0 = mem[rd_q];
  assign head1 = mem[ptr_inc(rd_q)];
  assign level = lvl_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= lvl_q); // R8

endmodule

// File: rtl/adc_ser_ctl.sv
module adc_ser_ctl
  import adc_ser_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode_in,
  input  logic [CW-1:0]    level,
  output logic             load,
  output logic             take,
  output logic [1:0]       pop_n,
  output logic             run,
  output logic             dco,
  output logic             fr,
  output mode_t            mode_q
);

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q;
  logic             run_d, dco_q, dco_d;
  mode_t            mode_d;
  logic [1:0]       need;
  logic             have, at_end;

  assign per_q = frame_periods(mode_q);

  always_comb begin
    need   = pair_frame(mode_in) ? 2'd2 : 2'd1;
    have   = level >= CW'(need);
    at_end = cnt_q == (per_q - 1'b1);
    load   = run ? at_end : have;
    take   = load && have;
    pop_n  = take ? need : 2'd0;

    run_d  = run | load;
    cnt_d  = load ? '0 : (run ? cnt_q + 1'b1 : cnt_q);
    mode_d = load ? mode_in : mode_q;
    dco_d  = run ? ~dco_q : load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt_q  <= '0;
      mode_q <= '0;
      dco_q  <= 1'b0;
    end else begin
      run    <= run_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      dco_q  <= dco_d;
    end
  end

  assign dco = dco_q;
  assign fr  = run && ({cnt_q, 1'b0} < {1'b0, per_q});

  AST_DCO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (dco_q != $past(dco_q))); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(mode_q)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < per_q)); // R3

endmodule

// File: rtl/adc_ser_shift.sv
module adc_ser_shift
  import adc_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             take,
  input  logic             run,
  input  mode_t            mode_in,
  input  mode_t            mode_q,
  input  logic [SMP_W-1:0] head0,
  input  logic [SMP_W-1:0] head1,
  output logic             lane0,
  output logic             lane1
);

  logic [WORD_W-1:0] sreg_q, sreg_d;

  always_comb begin
    if (load)
      sreg_d = take ? build_word(mode_in, head0, head1) : '0;
    else if (run)
      sreg_d = mode_q.two_lane ? {sreg_q[WORD_W-3:0], 2'b00}
                               : {sreg_q[WORD_W-2:0], 1'b0};
    else
      sreg_d = sreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign lane0 = run && sreg_q[WORD_W-1];
  assign lane1 = run && mode_q.two_lane && sreg_q[WORD_W-2];

endmodule

// File: rtl/adc_ser_formatter.sv
module adc_ser_formatter
  import adc_ser_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [13:0]      smp_data,
  input  logic             smp_vld,
  input  logic             lane_sel,
  input  logic [1:0]       ser_len,
  output logic             lane_a,
  output logic             lane_b,
  output logic             bit_clk_out,
  output logic             frame_mark
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  mode_t            mode_in, mode_q;
  logic [SMP_W-1:0] head0, head1;
  logic [LVL_W-1:0] level;
  logic [1:0]       pop_n;
  logic             load, take, run;

  assign mode_in = '{two_lane: lane_sel, len: len_e'(ser_len)};

  adc_ser_fifo #(.DEPTH(FIFO_DEPTH), .W(SMP_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (smp_vld),
    .din   (smp_data),
    .pop_n (pop_n),
    .head0 (head0),
    .head1 (head1),
    .level (level)
  );

  adc_ser_ctl #(.CW(LVL_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (mode_in),
    .level   (level),
    .load    (load),
    .take    (take),
    .pop_n   (pop_n),
    .run     (run),
    .dco     (bit_clk_out),
    .fr      (frame_mark),
    .mode_q  (mode_q)
  );

  adc_ser_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .take    (take),
    .run     (run),
    .mode_in (mode_in),
    .mode_q  (mode_q),
    .head0   (head0),
    .head1   (head1),
    .lane0   (lane_a),
    .lane1   (lane_b)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(lane_a || lane_b || bit_clk_out || frame_mark)); // R1

endmodule

// File: tb/adc_ser_formatter_tb.sv
module adc_ser_formatter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 6;
  // {two_lane, len, sample_a, sample_b}
  localparam logic [30:0] VEC [VEC_N] = '{
    {1'b0, 2'd0, 14'h2A5B, 14'h0000},
    {1'b0, 2'd1, 14'h1C3E, 14'h0000},
    {1'b0, 2'd2, 14'h3FF1, 14'h0000},
    {1'b1, 2'd0, 14'h1234, 14'h0000},
    {1'b1, 2'd1, 14'h0F0F, 14'h2AC3},
    {1'b1, 2'd2, 14'h3A5C, 14'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] smp_data;
  logic        smp_vld;
  logic        lane_sel;
  logic [1:0]  ser_len;
  logic        lane_a, lane_b, bit_clk_out, frame_mark;

  int  total = 0;
  int  bad = 0;
  logic dco_exp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_ser_formatter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_data    (smp_data),
    .smp_vld     (smp_vld),
    .lane_sel    (lane_sel),
    .ser_len     (ser_len),
    .lane_a      (lane_a),
    .lane_b      (lane_b),
    .bit_clk_out (bit_clk_out),
    .frame_mark  (frame_mark)
  );

  function automatic int exp_per(logic two, logic [1:0] len);
    int base;
    base = (len == 2'd1) ? 14 : (len == 2'd2) ? 12 : 16;
    if (two) base = (len == 2'd1) ? 14 : base / 2;
    return base;
  endfunction

  function automatic logic [27:0] exp_word(logic two, logic [1:0] len,
                                           logic [13:0] a, logic [13:0] b);
    if (len == 2'd1) return two ? {a, b} : {a, 14'h0};
    if (len == 2'd2) return {a[13:2], 16'h0};
    return {a, 14'h0};
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b (lane_a lane_b frame_mark bit_clk_out)",
               tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    logic [3:0] act;
    act = {lane_a, lane_b, frame_mark, bit_clk_out};
    check(act == 4'b0, tag, act, 4'b0);
  endtask

  task automatic do_reset();
    smp_vld = 1'b0;
    smp_data = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Pushes the first samples from idle; leaves the bench at the negedge
  // just before the load edge.
  task automatic start_frames(input logic two, input logic [1:0] len,
                              input logic [13:0] a, input logic [13:0] b);
    lane_sel = two;
    ser_len = len;
    smp_vld = 1'b1;
    smp_data = a;
    @(posedge clk);
    @(negedge clk);
    if (two && len == 2'd1) begin
      check_idle("R2 idle with one of two samples");
      smp_data = b;
      @(posedge clk);
      @(negedge clk);
    end
    smp_vld = 1'b0;
    check_idle("R2 idle before first load");
    dco_exp = 1'b1;
  endtask

  // Checks one frame, one bit period per cycle; optional push / mode change
  // at the negedge after period push_at / chg_at.
  task automatic check_frame(input logic two, input logic [1:0] len,
                             input logic [13:0] a, input logic [13:0] b,
                             input int push_at, input logic [13:0] push_val,
                             input int chg_at, input logic chg_two,
                             input logic [1:0] chg_len, input string tag);
    int per;
    logic [27:0] w;
    logic [3:0] act, exp;
    per = exp_per(two, len);
    w = exp_word(two, len, a, b);
    for (int k = 0; k < per; k++) begin
      @(posedge clk);
      @(negedge clk);
      smp_vld = 1'b0;
      exp[3] = two ? w[27 - 2 * k] : w[27 - k];
      exp[2] = two ? w[26 - 2 * k] : 1'b0;
      exp[1] = (2 * k) < per;
      exp[0] = dco_exp;
      dco_exp = ~dco_exp;
      act = {lane_a, lane_b, frame_mark, bit_clk_out};
      check(act == exp, tag, act, exp);
      if (k == push_at) begin
        smp_vld = 1'b1;
        smp_data = push_val;
      end
      if (k == chg_at) begin
        lane_sel = chg_two;
        ser_len = chg_len;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    lane_sel = 1'b0;
    ser_len = 2'd0;
    dco_exp = 1'b1;

    // R1: reset and idle with no samples
    do_reset();
    repeat (5) begin
      @(negedge clk);
      check_idle("R1 idle without samples");
    end

    // Table: every format, data frame then an underrun frame (R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < VEC_N; v++) begin
      logic        two;
      logic [1:0]  len;
      logic [13:0] a, b;
      {two, len, a, b} = VEC[v];
      do_reset();
      start_frames(two, len, a, b);
      check_frame(two, len, a, b, -1, '0, -1, 1'b0, 2'd0, "R3/R4/R5/R6/R7 table frame");
      check_frame(two, len, '0, '0, -1, '0, -1, 1'b0, 2'd0, "R8 table underrun frame");
    end

    // R8: strobe on the boundary edge is sent one frame later
    do_reset();
    start_frames(1'b0, 2'd2, 14'h1357, '0);
    check_frame(1'b0, 2'd2, 14'h1357, '0, 11, 14'h2468, -1, 1'b0, 2'd0, "R8 boundary frame A");
    check_frame(1'b0, 2'd2, '0, '0, -1, '0, -1, 1'b0, 2'd0, "R8 boundary zero frame");
    check_frame(1'b0, 2'd2, 14'h2468, '0, -1, '0, -1, 1'b0, 2'd0, "R8 boundary late sample");

    // R2: strobe in mid-frame is used by the very next frame
    do_reset();
    start_frames(1'b1, 2'd0, 14'h0ACE, '0);
    check_frame(1'b1, 2'd0, 14'h0ACE, '0, 3, 14'h3BD1, -1, 1'b0, 2'd0, "R2 mid push frame A");
    check_frame(1'b1, 2'd0, 14'h3BD1, '0, -1, '0, -1, 1'b0, 2'd0, "R2 mid push next frame");

    // R9: format change mid-frame takes effect at the next load
    do_reset();
    start_frames(1'b0, 2'd1, 14'h2D4B, '0);
    check_frame(1'b0, 2'd1, 14'h2D4B, '0, 1, 14'h1E87, 4, 1'b1, 2'd2, "R9 old format kept");
    check_frame(1'b1, 2'd2, 14'h1E87, '0, -1, '0, -1, 1'b0, 2'd0, "R9 new format frame");

    // R8/R4: pair format with only one sample at a boundary
    do_reset();
    start_frames(1'b1, 2'd1, 14'h3C01, 14'h0C3F);
    check_frame(1'b1, 2'd1, 14'h3C01, 14'h0C3F, 2, 14'h1111, -1, 1'b0, 2'd0, "R4 pair frame");
    check_frame(1'b1, 2'd1, '0, '0, 2, 14'h2222, -1, 1'b0, 2'd0, "R8 pair short zero frame");
    check_frame(1'b1, 2'd1, 14'h1111, 14'h2222, -1, '0, -1, 1'b0, 2'd0, "R4 pair after wait");

    // R1: reset asserted during a frame clears outputs at once
    do_reset();
    start_frames(1'b0, 2'd0, 14'h3FFF, '0);
    check_frame(1'b0, 2'd0, 14'h3FFF, '0, -1, '0, -1, 1'b0, 2'd0, "R5 all-ones frame");
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset mid-frame");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_idle("R1 idle after mid-frame reset");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule